// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast synchronous clock by an integer ratio N = P·B + A. It pairs a dual-modulus prescaler that divides by P or P+1 with two counters. The swallow counter A sets how many prescaler cycles run at P+1. The main counter B sets how many prescaler cycles make up one output period. While the swallow count is nonzero, the prescaler runs at P+1. Once it reaches zero, the prescaler runs at P for the rest of the period. When B expires, both counters reload and one divided pulse is produced.

A hold input represents power-down or counter reset. While hold is high, the prescaler and both counters stay in their load state and take the current A, B and prescaler-select values. Outside hold, new settings are taken only when a period ends, so a period already in progress is never disturbed. A registered error flag reports settings that cannot give the intended ratio.

Top module: `swallow_divider`

## Requirements
- R1: Between two consecutive `div_out` pulses there are exactly P·B + A clock cycles, with P taken from `p_sel`.
- R2: `div_out` is high for one clock cycle per period and low in the cycle after a pulse.
- R3: `p_sel` selects the base modulus: 2'b00 gives P=4, 2'b01 gives P=8, 2'b10 gives P=16, and the reserved code 2'b11 behaves as P=16.
- R4: In each period, `mod_ctrl` is high for the first A·(P+1) cycles and low for the remaining cycles. When A=0 it never goes high.
- R5: While `hold` is high, `div_out` stays low and `mod_ctrl` equals (A != 0) for the A on the inputs one cycle earlier. After `hold` falls, the first pulse appears N rising edges later, counting the first edge with `hold` low as edge 1.
- R6: Outside hold, changes to `a_val`, `b_val` or `p_sel` take effect only in the period that starts with the next pulse.
- R7: `cfg_err` goes high one cycle after the inputs show A > B, B < 3, or `p_sel` = 2'b11, and goes low one cycle after none of these holds.
- R8: While `rst_n` is low, `div_out`, `mod_ctrl` and `cfg_err` are all 0.
- R9: The ratio holds at the edges of the legal ranges: B=3, B=4095, A=0 and A=63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Power-down / counter reset; forces the load state |
| p_sel | input | 2 | Prescaler base modulus select |
| a_val | input | 6 | Swallow count A |
| b_val | input | 12 | Main count B |
| mod_ctrl | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Registered flag for an invalid setting |

## Verification
Random settings spread over all three moduli and a wide span of A and B, including A equal to B. They separate a correct P·B + A count from off-by-one errors in either counter or in the prescaler terminal count. Directed cases use A=0, A=63, B=3 and B=4095. They show whether the swallow phase is skipped cleanly and whether the counters wrap correctly. The count of high `mod_ctrl` cycles in each period checks that the P+1 phase lasts exactly A prescaler cycles. A setting changed in the middle of a period checks that the old ratio finishes before the new one starts. The error cases check each of the three invalid conditions on its own.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
    localparam int A_W    = 6;
    localparam int B_W    = 12;
    localparam int PSEL_W = 2;
    localparam int PC_W   = 5;
    localparam int B_MIN  = 3;

    // base modulus P for a select code; the reserved code runs as 16
    function automatic logic [PC_W-1:0] base_mod(input logic [PSEL_W-1:0] sel);
        logic [PC_W-1:0] p;
        case (sel)
            2'b00:   p = PC_W'(4);
            2'b01:   p = PC_W'(8);
            default: p = PC_W'(16);
        endcase
        return p;
    endfunction

    typedef struct packed {
        logic [A_W-1:0]  a_cnt;
        logic [B_W-1:0]  b_cnt;
        logic [PC_W-1:0] pval;
        logic            pulse;
    } ctrl_st_t;
endpackage

// File: rtl/sd_prescaler.sv
module sd_prescaler
    import swallow_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            mod_hi,
    input  logic [PC_W-1:0] pval,
    output logic            tick
);
    logic [PC_W-1:0] cnt_d, cnt_q;
    logic [PC_W-1:0] term;

    always_comb begin
        // terminal count: P cycles, or P+1 while swallowing
        term  = mod_hi ? pval : pval - PC_W'(1);
        tick  = !clear && (cnt_q == term);
        cnt_d = (clear || tick) ? '0 : cnt_q + PC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_swallow_ctrl.sv
module sd_swallow_ctrl
    import swallow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tick,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    input  logic [PSEL_W-1:0] p_sel,
    output logic              load,
    output logic              mod_hi,
    output logic [PC_W-1:0]   pval,
    output logic              pulse
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        load       = hold || (st_q.b_cnt == '0);
        if (load) begin
            st_d.a_cnt = a_val;
            st_d.b_cnt = b_val;
            st_d.pval  = base_mod(p_sel);
        end else if (tick) begin
            if (st_q.b_cnt <= B_W'(1)) begin
                // B expired: reload both counters and emit the pulse
                st_d.a_cnt = a_val;
                st_d.b_cnt = b_val;
                st_d.pval  = base_mod(p_sel);
                st_d.pulse = 1'b1;
            end else begin
                st_d.b_cnt = st_q.b_cnt - B_W'(1);
                if (st_q.a_cnt != '0) st_d.a_cnt = st_q.a_cnt - A_W'(1);
            end
        end
        mod_hi = (st_q.a_cnt != '0);
        pval   = st_q.pval;
        pulse  = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sd_cfg_check.sv
module sd_cfg_check
    import swallow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    input  logic [PSEL_W-1:0] p_sel,
    output logic              err
);
    logic err_d, err_q;

    always_comb begin
        err_d = (B_W'(a_val) > b_val) || (b_val < B_W'(B_MIN)) || (p_sel == '1);
        err   = err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [PSEL_W-1:0] p_sel,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    output logic              mod_ctrl,
    output logic              div_out,
    output logic              cfg_err
);
    logic            load, mod_hi, tick, pulse;
    logic [PC_W-1:0] pval;

    sd_swallow_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick),
        .a_val(a_val), .b_val(b_val), .p_sel(p_sel),
        .load(load), .mod_hi(mod_hi), .pval(pval), .pulse(pulse)
    );

    sd_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clear(load), .mod_hi(mod_hi),
        .pval(pval), .tick(tick)
    );

    sd_cfg_check u_cfg (
        .clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val),
        .p_sel(p_sel), .err(cfg_err)
    );

    assign mod_ctrl = mod_hi;
    assign div_out  = pulse;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk
    import swallow_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic [PSEL_W-1:0] p_sel,
    input logic [A_W-1:0]    a_val,
    input logic [B_W-1:0]    b_val,
    input logic              mod_ctrl,
    input logic              div_out,
    input logic              cfg_err
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_out);

    a_r5_hold_loads_a: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hold) |=> (mod_ctrl == ($past(a_val) != '0)));

    a_r4_pulse_starts_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && div_out) |-> (mod_ctrl == ($past(a_val) != '0)));

    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (cfg_err == $past((B_W'(a_val) > b_val) || (b_val < B_W'(B_MIN)) || (p_sel == 2'b11))));

    always_comb begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (!div_out && !mod_ctrl && !cfg_err);
        end
    end
endmodule

bind swallow_divider swallow_divider_chk u_chk (.*);

// File: tb/swallow_divider_test.sv
`timescale 1ns/100ps
module swallow_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b1;
    logic [1:0]  p_sel = 2'b00;
    logic [5:0]  a_val = '0;
    logic [11:0] b_val = 12'd3;
    logic        mod_ctrl, div_out, cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    swallow_divider uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .p_sel(p_sel),
        .a_val(a_val), .b_val(b_val),
        .mod_ctrl(mod_ctrl), .div_out(div_out), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    initial begin
        wait (cycles >= 195000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int pbase(input logic [1:0] s);
        return (s == 2'b00) ? 4 : (s == 2'b01) ? 8 : 16;
    endfunction

    function automatic int exp_n(input logic [1:0] s, input int a, input int b);
        return pbase(s) * b + a;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // count edges until the next pulse; also counts mod_ctrl-high samples
    task automatic wait_pulse(output int k, output int hi, output bit early);
        k = 0; hi = 0; early = 0;
        forever begin
            @(negedge clk);
            k++;
            if (div_out) break;
            if (k == 1 && div_out) early = 1;
            if (mod_ctrl) hi++;
            if (k > 70000) break;
        end
    endtask

    // load a setting through hold and measure first pulse plus one period
    task automatic run_cfg(input logic [1:0] s, input int a, input int b, input string tag);
        int k, hi, n, h0;
        bit early;
        @(negedge clk);
        p_sel = s; a_val = 6'(a); b_val = 12'(b); hold = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(div_out == 1'b0, {tag, " R5 hold div_out"}, div_out, 0);
        chk(mod_ctrl == (a != 0), {tag, " R5 hold mod_ctrl"}, mod_ctrl, a != 0);
        hold = 1'b0;
        n = exp_n(s, a, b);
        wait_pulse(k, hi, early);
        chk(k == n, {tag, " R5 first pulse"}, k, n);
        h0 = mod_ctrl ? 1 : 0;
        wait_pulse(k, hi, early);
        chk(k == n, {tag, " R1 period"}, k, n);
        chk(hi + h0 == a * (pbase(s) + 1), {tag, " R4 swallow cycles"}, hi + h0, a * (pbase(s) + 1));
    endtask

    initial begin
        int k, hi, n_old, n_new;
        bit early;
        // R8 reset
        repeat (3) @(negedge clk);
        chk(div_out == 0, "R8 div_out", div_out, 0);
        chk(mod_ctrl == 0, "R8 mod_ctrl", mod_ctrl, 0);
        chk(cfg_err == 0, "R8 cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        // R3 each modulus, R9 boundaries
        run_cfg(2'b00, 0, 3, "R3 P4 R9 B3 A0");
        run_cfg(2'b01, 3, 3, "R3 P8 A=B");
        run_cfg(2'b10, 63, 63, "R3 P16 R9 A63");
        run_cfg(2'b11, 1, 3, "R3 reserved");
        run_cfg(2'b00, 0, 4095, "R9 B4095");

        // R2 one-cycle pulse
        @(negedge clk);
        wait_pulse(k, hi, early);
        @(negedge clk);
        chk(div_out == 0, "R2 pulse width", div_out, 0);

        // random settings
        void'($urandom(32'h5a17));
        for (int i = 0; i < 10; i++) begin
            logic [1:0] s;
            int b, a;
            s = 2'($urandom_range(0, 2));
            b = $urandom_range(3, 120);
            a = $urandom_range(0, (b < 63) ? b : 63);
            run_cfg(s, a, b, "R1 random");
        end

        // R6 mid-period change
        run_cfg(2'b01, 5, 10, "R6 base");
        n_old = exp_n(2'b01, 5, 10);
        n_new = exp_n(2'b00, 2, 7);
        @(negedge clk);
        p_sel = 2'b00; a_val = 6'd2; b_val = 12'd7;
        wait_pulse(k, hi, early);
        chk(k == n_old - 1, "R6 old ratio kept", k, n_old - 1);
        wait_pulse(k, hi, early);
        chk(k == n_new, "R6 new ratio", k, n_new);

        // R7 error flag
        @(negedge clk); a_val = 6'd10; b_val = 12'd5; p_sel = 2'b00;
        @(negedge clk);
        chk(cfg_err == 1, "R7 A>B", cfg_err, 1);
        a_val = 6'd0; b_val = 12'd2;
        @(negedge clk);
        chk(cfg_err == 1, "R7 B<3", cfg_err, 1);
        b_val = 12'd3; p_sel = 2'b11;
        @(negedge clk);
        chk(cfg_err == 1, "R7 reserved sel", cfg_err, 1);
        p_sel = 2'b10;
        @(negedge clk);
        chk(cfg_err == 0, "R7 clear", cfg_err, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule